// File: doc/BRIEF.md
# Touch Burst Validation Filter

This block turns a burst of queued touch-panel conversions into one position report. When its trigger fires, it reads up to four words from a touch-sample FIFO, one at a time. It maps each 10-bit coordinate into the panel's orientation by inverting it. It then decides whether the burst is a real touch. A good burst yields a position with the touch flag set. Any other burst yields a release report that keeps the last good position.

If the FIFO has flagged an overrun when the trigger arrives, the block drains the FIFO to empty. It throws the data away and reports nothing. The FIFO read port is the registered-read kind: a pop in one cycle presents the popped word in the next cycle.

Top module: `touch_burst_filter`

## Requirements
- R1: After reset `pos_x_o`, `pos_y_o`, `touch_o`, `valid_o` and `fifo_pop_o` are all 0.
- R2: A trigger that arrives while `fifo_ovr_i` is high pops the FIFO until `fifo_empty_i` is high, and no report follows.
- R3: A normal trigger pops at most 4 entries. Popping stops early as soon as `fifo_empty_i` is high, and the remaining entries stay in the FIFO.
- R4: The raw X coordinate is word bits 25:16 and the raw Y coordinate is word bits 9:0. Each is converted to 1023 minus its raw value.
- R5: A burst is a touch only when exactly 4 entries were popped and bit 31 of the fourth entry is 0. Bit 31 of the other entries has no effect.
- R6: For a touch, `pos_x_o` and `pos_y_o` are each the truncated mean of the converted coordinates of the second and third entries, and `touch_o` is 1.
- R7: For any other burst, `touch_o` is 0 and `pos_x_o`/`pos_y_o` keep their previous values.
- R8: Each normal burst ends with exactly one single-cycle `valid_o` pulse. The pulse carries X, Y and the touch flag together.
- R9: Triggers that arrive while a burst or a flush is in progress are ignored.
- R10: `fifo_pop_o` is never asserted while `fifo_empty_i` is high, and the block issues at most one pop per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | 1 | Start a burst (one-cycle pulse) |
| fifo_ovr_i | input | 1 | FIFO overrun status |
| fifo_data_i | input | 32 | FIFO read data, valid the cycle after a pop |
| fifo_empty_i | input | 1 | FIFO empty flag |
| fifo_pop_o | output | 1 | FIFO pop strobe |
| pos_x_o | output | 10 | Reported X coordinate |
| pos_y_o | output | 10 | Reported Y coordinate |
| touch_o | output | 1 | Touch flag of the last report |
| valid_o | output | 1 | One-cycle report strobe |

## Verification
The bench loads bursts of 0 to 6 entries with the last-entry pen bit both set and clear. It uses coordinate patterns that include the extremes 0 and 1023, then compares every report with arithmetic done in the bench. A design that accepted three-entry bursts, or looked at the pen bit of the wrong entry, would report a touch where the bench expects a release. A design that averaged the wrong pair, or that skipped or misplaced the inversion, would give coordinates off from the computed means. Overrun drains are checked to leave the FIFO empty without a report. Six-entry bursts are checked to leave two entries behind. A second trigger injected mid-burst must not cause extra pops or a second strobe. The held coordinates after a release expose a design that clears or updates position on bad bursts.

// File: rtl/tbf_pkg.sv
package tbf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POP,
    ST_CAPT,
    ST_DECIDE,
    ST_FLUSH
  } tbf_state_e;
endpackage

// File: rtl/tbf_ctrl.sv
module tbf_ctrl
  import tbf_pkg::*;
#(
  parameter int NSAMP = 4,
  localparam int CW = $clog2(NSAMP + 1),
  localparam int IW = $clog2(NSAMP)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          fifo_ovr_i,
  input  logic          fifo_empty_i,
  output logic          fifo_pop_o,
  output logic          cap_en_o,
  output logic [IW-1:0] cap_idx_o,
  output logic          decide_o,
  output logic          full_o
);

  tbf_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    fifo_pop_o = 1'b0;
    cap_en_o   = 1'b0;
    decide_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (trig_i) begin
        cnt_d   = '0;
        state_d = fifo_ovr_i ? ST_FLUSH : ST_POP;
      end
      ST_POP: begin
        if (fifo_empty_i || cnt_q == CW'(NSAMP)) begin
          state_d = ST_DECIDE;
        end else begin
          fifo_pop_o = 1'b1;
          state_d    = ST_CAPT;
        end
      end
      ST_CAPT: begin
        cap_en_o = 1'b1;
        cnt_d    = cnt_q + 1'b1;
        state_d  = ST_POP;
      end
      ST_DECIDE: begin
        decide_o = 1'b1;
        state_d  = ST_IDLE;
      end
      ST_FLUSH: begin
        if (fifo_empty_i) state_d = ST_IDLE;
        else fifo_pop_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cap_idx_o = cnt_q[IW-1:0];
  assign full_o    = (cnt_q == CW'(NSAMP));

  p_no_pop_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> !fifo_empty_i);
  p_pop_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_pop_o && state_q != ST_FLUSH) |-> (cnt_q < CW'(NSAMP)));

endmodule

// File: rtl/tbf_capture.sv
module tbf_capture #(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int NSAMP   = 4,
  parameter int MID     = 1,
  localparam int IW     = $clog2(NSAMP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_en_i,
  input  logic [IW-1:0]      cap_idx_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [COORD_W-1:0] x_o [2],
  output logic [COORD_W-1:0] y_o [2],
  output logic               pen_up_o
);

  localparam logic [COORD_W-1:0] MAXV = '1;

  logic [COORD_W-1:0] x_cv, y_cv;
  assign x_cv = MAXV - data_i[X_LSB +: COORD_W];
  assign y_cv = MAXV - data_i[Y_LSB +: COORD_W];

  for (genvar g = 0; g < 2; g++) begin : g_mid
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        x_o[g] <= '0;
        y_o[g] <= '0;
      end else if (cap_en_i && cap_idx_i == IW'(MID + g)) begin
        x_o[g] <= x_cv;
        y_o[g] <= y_cv;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pen_up_o <= 1'b1;
    else if (cap_en_i && cap_idx_i == IW'(NSAMP - 1)) pen_up_o <= data_i[PEN_BIT];
  end

endmodule

// File: rtl/tbf_report.sv
module tbf_report #(
  parameter int COORD_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               decide_i,
  input  logic               full_i,
  input  logic               pen_up_i,
  input  logic [COORD_W-1:0] x_i [2],
  input  logic [COORD_W-1:0] y_i [2],
  output logic [COORD_W-1:0] pos_x_o,
  output logic [COORD_W-1:0] pos_y_o,
  output logic               touch_o,
  output logic               valid_o
);

  logic [COORD_W:0] x_sum, y_sum;
  logic             good;
  assign x_sum = {1'b0, x_i[0]} + {1'b0, x_i[1]};
  assign y_sum = {1'b0, y_i[0]} + {1'b0, y_i[1]};
  assign good  = full_i && !pen_up_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_x_o <= '0;
      pos_y_o <= '0;
      touch_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= decide_i;
      if (decide_i) begin
        touch_o <= good;
        if (good) begin
          pos_x_o <= x_sum[COORD_W:1];
          pos_y_o <= y_sum[COORD_W:1];
        end
      end
    end
  end

  p_strobe_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_hold_on_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !touch_o) |-> (pos_x_o == $past(pos_x_o) && pos_y_o == $past(pos_y_o)));

endmodule

// File: rtl/touch_burst_filter.sv
module touch_burst_filter #(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int NSAMP   = 4,
  parameter int MID     = 1,
  localparam int IW     = $clog2(NSAMP)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               trig_i,
  input  logic               fifo_ovr_i,
  input  logic [DATA_W-1:0]  fifo_data_i,
  input  logic               fifo_empty_i,
  output logic               fifo_pop_o,
  output logic [COORD_W-1:0] pos_x_o,
  output logic [COORD_W-1:0] pos_y_o,
  output logic               touch_o,
  output logic               valid_o
);

  logic               cap_en, decide, full, pen_up;
  logic [IW-1:0]      cap_idx;
  logic [COORD_W-1:0] xs [2];
  logic [COORD_W-1:0] ys [2];

  tbf_ctrl #(.NSAMP(NSAMP)) i_ctrl (
    .clk_i, .rst_ni, .trig_i, .fifo_ovr_i, .fifo_empty_i, .fifo_pop_o,
    .cap_en_o(cap_en), .cap_idx_o(cap_idx), .decide_o(decide), .full_o(full)
  );

  tbf_capture #(
    .DATA_W(DATA_W), .COORD_W(COORD_W), .X_LSB(X_LSB), .Y_LSB(Y_LSB),
    .PEN_BIT(PEN_BIT), .NSAMP(NSAMP), .MID(MID)
  ) i_capture (
    .clk_i, .rst_ni, .cap_en_i(cap_en), .cap_idx_i(cap_idx),
    .data_i(fifo_data_i), .x_o(xs), .y_o(ys), .pen_up_o(pen_up)
  );

  tbf_report #(.COORD_W(COORD_W)) i_report (
    .clk_i, .rst_ni, .decide_i(decide), .full_i(full), .pen_up_i(pen_up),
    .x_i(xs), .y_i(ys), .pos_x_o, .pos_y_o, .touch_o, .valid_o
  );

endmodule

// File: tb/test_touch_burst_filter.sv
module test_touch_burst_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        ovr = 1'b0;
  logic [31:0] fdata = '0;
  logic        fempty;
  logic        pop;
  logic [9:0]  px, py;
  logic        touch, valid;

  int checks = 0;
  int errors = 0;
  logic [31:0] fmem [8];
  int frd = 0;
  int fcount = 0;
  int pops = 0;
  int exp_x = 0;
  int exp_y = 0;

  always #4 clk = ~clk;

  assign fempty = (fcount == 0);

  always @(posedge clk) begin
    if (pop) begin
      fdata  <= fmem[frd];
      frd    <= frd + 1;
      fcount <= fcount - 1;
      pops   <= pops + 1;
    end
  end

  touch_burst_filter i_touch_burst_filter (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig), .fifo_ovr_i(ovr),
    .fifo_data_i(fdata), .fifo_empty_i(fempty), .fifo_pop_o(pop),
    .pos_x_o(px), .pos_y_o(py), .touch_o(touch), .valid_o(valid)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int raw_x(int k, int s, int mode);
    return (mode == 3) ? 0 : ((s * 37 + k * 101 + 5) & 1023);
  endfunction
  function automatic int raw_y(int k, int s, int mode);
    return (mode == 3) ? 1023 : ((s * 53 + k * 29 + 7) & 1023);
  endfunction

  // n entries; pen bit of entry 3 = pen_last, other entries' pen bit = mode[0]
  task automatic load(int n, int s, int mode, bit pen_last);
    for (int k = 0; k < n; k++) begin
      logic pb;
      pb = (k == 3) ? pen_last : mode[0];
      fmem[k] = {pb, 5'd0, 10'(raw_x(k, s, mode)), 6'd0, 10'(raw_y(k, s, mode))};
    end
    frd = 0;
    fcount = n;
    pops = 0;
  endtask

  task automatic run(int n, int s, int mode, bit pen_last, bit overrun, bit extra_trig);
    int vcnt = 0;
    int lx = 0, ly = 0, lt = 0;
    bit good;
    load(n, s, mode, pen_last);
    ovr = overrun;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (extra_trig && c == 3) trig = 1'b1;
      if (extra_trig && c == 4) trig = 1'b0;
      if (valid) begin
        vcnt++;
        lx = px; ly = py; lt = touch;
      end
      @(negedge clk);
    end
    ovr = 1'b0;
    if (overrun) begin
      check("R2 flush pops", pops, n);
      check("R2 fifo drained", fcount, 0);
      check("R2 no report", vcnt, 0);
      return;
    end
    check("R3 pops", pops, (n < 4) ? n : 4);
    check("R3 R9 remaining", fcount, (n < 4) ? 0 : n - 4);
    check("R8 R9 one strobe", vcnt, 1);
    good = (n == 4 || n > 4) && !pen_last;
    if (good) begin
      exp_x = ((1023 - raw_x(1, s, mode)) + (1023 - raw_x(2, s, mode))) / 2;
      exp_y = ((1023 - raw_y(1, s, mode)) + (1023 - raw_y(2, s, mode))) / 2;
    end
    check("R5 touch flag", lt, good ? 1 : 0);
    check(good ? "R4 R6 x" : "R7 x held", lx, exp_x);
    check(good ? "R4 R6 y" : "R7 y held", ly, exp_y);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 x", px, 0);
    check("R1 y", py, 0);
    check("R1 touch", touch, 0);
    check("R1 valid", valid, 0);
    check("R1 pop", pop, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n <= 6; n++)
      for (int p = 0; p < 2; p++)
        for (int m = 0; m < 4; m++)
          run(n, n * 8 + p * 4 + m, m, p[0], 1'b0, n == 6);
    // R7: good touch, then a release must keep the coordinates
    run(4, 11, 0, 1'b0, 1'b0, 1'b0);
    run(4, 12, 0, 1'b1, 1'b0, 1'b0);
    run(3, 13, 0, 1'b0, 1'b0, 1'b0);
    for (int n = 0; n <= 6; n++) run(n, 20 + n, 1, 1'b0, 1'b1, 1'b0);
    run(5, 30, 2, 1'b0, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule